// File: doc/BRIEF.md
# Shared PLL Vote Arbiter

This block decides when a PLL shared by several masters runs. Each master owns one bit of a vote mask. Setting the bit asks for the PLL and clearing it withdraws the request. Votes arrive on two paths: per-master hardware set and clear strobes, and a small register port that the host processor uses. All changes in a cycle are merged, so concurrent updates are never lost. When the mask goes from empty to non-empty, the block asks an external PLL sequencer to start the PLL. It raises an "on" flag when the sequencer acknowledges. It then polls the PLL's ready indication at a fixed interval for a bounded number of polls.

If the PLL reports ready during polling, the block raises a ready flag. If polling runs out first, the block sets a sticky timeout flag, which the host clears by writing a one to it. The block asks the sequencer to stop the PLL only when the on flag is set and no vote remains. A vote that arrives during a stop does not cancel it: the stop completes and the PLL is started again at once.

At reset the vote mask is loaded from a hand-off input. If the host's own bit is set in that mask, the PLL is taken to be already running and ready, and no start request is issued.

Top module: `pll_vote_arbiter`

## Requirements
- R1: Under reset the vote mask loads `boot_votes`. If bit `HOST_BIT` of it is set, `pll_on` and `pll_ready` come up 1 and `start_req` stays 0. Otherwise `pll_on`, `pll_ready`, `timeout_err`, `start_req` and `stop_req` are 0.
- R2: In each cycle, every bit set in `hw_vote_set`, or in `reg_wdata` on a write to address 0, becomes 1 in the vote mask. A read at address 0 returns the mask in `reg_rdata` two edges after the change that caused it.
- R3: Bits set in `hw_vote_clr`, or in `reg_wdata` on a write to address 1, become 0 in the mask. If the same bit is set and cleared in one cycle, the set wins.
- R4: When the mask becomes non-empty while the PLL is off, `start_req` rises and stays high until `start_ack` is seen.
- R5: `pll_on` becomes 1 on the edge where `start_ack` is seen during a start.
- R6: After start, `pll_ready_in` is sampled once every `POLL_GAP` cycles. `pll_ready` becomes 1 after a sample finds it high, and `pll_ready` is never 1 while `pll_on` is 0.
- R7: If `POLL_LIMIT` samples all find `pll_ready_in` low, `timeout_err` becomes 1 and stays 1, and `pll_ready` stays 0.
- R8: A write to address 2 with bit 3 of `reg_wdata` high clears `timeout_err`. A write to address 2 with bit 3 low leaves it set. A read at address 2 returns {timeout, ready, on, busy} in bits 3..0.
- R9: `stop_req` rises only when the PLL is on and the vote mask is empty. `pll_ready` drops at the same time.
- R10: `pll_on` clears on the edge where `stop_ack` is seen. If votes are present at that point, `start_req` rises again.
- R11: `start_req` and `stop_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_votes | input | N_MASTERS | Vote mask loaded during reset (hand-off) |
| hw_vote_set | input | N_MASTERS | Per-master vote set strobes |
| hw_vote_clr | input | N_MASTERS | Per-master vote clear strobes |
| reg_addr | input | 2 | Register address: 0 set/read votes, 1 clear votes, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | N_MASTERS | Register write data |
| reg_rdata | output | N_MASTERS | Registered read data for `reg_addr` |
| start_req | output | 1 | Request to sequencer to start the PLL |
| start_ack | input | 1 | Sequencer start acknowledge |
| stop_req | output | 1 | Request to sequencer to stop the PLL |
| stop_ack | input | 1 | Sequencer stop acknowledge |
| pll_ready_in | input | 1 | PLL output-usable indication |
| pll_on | output | 1 | PLL on flag |
| pll_ready | output | 1 | PLL confirmed ready |
| timeout_err | output | 1 | Sticky ready-timeout error |

## Verification
The bench builds the block with four masters, host bit 1, a poll gap of 3 cycles and a poll limit of 5. With these values a complete timeout, 15 cycles of polling, fits inside a short directed test, so the limit boundary is checked on both sides. Four masters are enough to exercise set/clear collisions, multi-bit merges and a last-vote removal that comes from a master other than the host. The hand-off path is covered by a second reset with the host bit preset.

// File: rtl/pva_pkg.sv
package pva_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_START,
    ST_POLL,
    ST_ON,
    ST_STOP
  } pva_state_e;

  localparam logic [1:0] ADDR_VOTE_SET = 2'd0;
  localparam logic [1:0] ADDR_VOTE_CLR = 2'd1;
  localparam logic [1:0] ADDR_STATUS   = 2'd2;

  localparam int STAT_BUSY  = 0;
  localparam int STAT_ON    = 1;
  localparam int STAT_READY = 2;
  localparam int STAT_TMO   = 3;
endpackage

// File: rtl/pva_vote_reg.sv
module pva_vote_reg #(
  parameter int N_MASTERS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] boot_votes,
  input  logic [N_MASTERS-1:0] set_mask,
  input  logic [N_MASTERS-1:0] clr_mask,
  output logic [N_MASTERS-1:0] votes,
  output logic                 vote_any
);
  always_ff @(posedge clk) begin
    if (rst) votes <= boot_votes;
    else     votes <= (votes & ~clr_mask) | set_mask;
  end

  assign vote_any = |votes;

  assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (|set_mask) |=> ((votes & $past(set_mask)) == $past(set_mask)));

  assert_clear_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (|(clr_mask & ~set_mask)) |=> ((votes & $past(clr_mask & ~set_mask)) == '0));
endmodule

// File: rtl/pva_poll_timer.sv
module pva_poll_timer #(
  parameter int POLL_GAP   = 200,
  parameter int POLL_LIMIT = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick,
  output logic last
);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] poll_cnt;

  assign tick = run && (gap_cnt == GW'(POLL_GAP - 1));
  assign last = tick && (poll_cnt == PW'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      gap_cnt  <= '0;
      poll_cnt <= '0;
    end else if (tick) begin
      gap_cnt  <= '0;
      poll_cnt <= poll_cnt + 1'b1;
    end else begin
      gap_cnt  <= gap_cnt + 1'b1;
    end
  end

  assert_poll_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    run |-> (poll_cnt < PW'(POLL_LIMIT)));
endmodule

// File: rtl/pva_seq_fsm.sv
module pva_seq_fsm
  import pva_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic boot_on,
  input  logic vote_any,
  input  logic start_ack,
  input  logic stop_ack,
  input  logic poll_tick,
  input  logic poll_last,
  input  logic lock_seen,
  output logic start_req,
  output logic stop_req,
  output logic pll_on,
  output logic pll_ready,
  output logic poll_run,
  output logic busy,
  output logic timeout_hit
);
  pva_state_e state;

  assign poll_run = (state == ST_POLL);
  assign busy     = (state == ST_START) || (state == ST_POLL) || (state == ST_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= boot_on ? ST_ON : ST_OFF;
      pll_on      <= boot_on;
      pll_ready   <= boot_on;
      start_req   <= 1'b0;
      stop_req    <= 1'b0;
      timeout_hit <= 1'b0;
    end else begin
      timeout_hit <= 1'b0;
      unique case (state)
        ST_OFF: if (vote_any) begin
          start_req <= 1'b1;
          state     <= ST_START;
        end
        ST_START: if (start_ack) begin
          start_req <= 1'b0;
          pll_on    <= 1'b1;
          state     <= ST_POLL;
        end
        ST_POLL: if (poll_tick) begin
          if (lock_seen) begin
            pll_ready <= 1'b1;
            state     <= ST_ON;
          end else if (poll_last) begin
            timeout_hit <= 1'b1;
            state       <= ST_ON;
          end
        end
        ST_ON: if (!vote_any) begin
          stop_req  <= 1'b1;
          pll_ready <= 1'b0;
          state     <= ST_STOP;
        end
        ST_STOP: if (stop_ack) begin
          stop_req <= 1'b0;
          pll_on   <= 1'b0;
          if (vote_any) begin
            start_req <= 1'b1;
            state     <= ST_START;
          end else begin
            state <= ST_OFF;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  assert_req_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(start_req && stop_req));

  assert_on_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && start_ack) |=> pll_on);

  assert_stop_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_req) |-> !$past(vote_any));

  assert_ready_needs_on_R6: assert property (@(posedge clk) disable iff (rst)
    pll_ready |-> pll_on);

  assert_off_on_stop_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP && stop_ack) |=> !pll_on);
endmodule

// File: rtl/pll_vote_arbiter.sv
module pll_vote_arbiter
  import pva_pkg::*;
#(
  parameter int N_MASTERS  = 8,
  parameter int HOST_BIT   = 1,
  parameter int POLL_GAP   = 200,
  parameter int POLL_LIMIT = 200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] boot_votes,
  input  logic [N_MASTERS-1:0] hw_vote_set,
  input  logic [N_MASTERS-1:0] hw_vote_clr,
  input  logic [1:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [N_MASTERS-1:0] reg_wdata,
  output logic [N_MASTERS-1:0] reg_rdata,
  output logic                 start_req,
  input  logic                 start_ack,
  output logic                 stop_req,
  input  logic                 stop_ack,
  input  logic                 pll_ready_in,
  output logic                 pll_on,
  output logic                 pll_ready,
  output logic                 timeout_err
);
  logic [N_MASTERS-1:0] set_mask, clr_mask, votes;
  logic vote_any, poll_run, poll_tick, poll_last, busy, timeout_hit;
  logic lock_q, tmo_clear;

  assign set_mask  = hw_vote_set | ((reg_wr && reg_addr == ADDR_VOTE_SET) ? reg_wdata : '0);
  assign clr_mask  = hw_vote_clr | ((reg_wr && reg_addr == ADDR_VOTE_CLR) ? reg_wdata : '0);
  assign tmo_clear = reg_wr && (reg_addr == ADDR_STATUS) && reg_wdata[STAT_TMO];

  pva_vote_reg #(.N_MASTERS(N_MASTERS)) u_votes (
    .clk(clk), .rst(rst), .boot_votes(boot_votes),
    .set_mask(set_mask), .clr_mask(clr_mask),
    .votes(votes), .vote_any(vote_any)
  );

  pva_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .run(poll_run), .tick(poll_tick), .last(poll_last)
  );

  pva_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .boot_on(boot_votes[HOST_BIT]), .vote_any(vote_any),
    .start_ack(start_ack), .stop_ack(stop_ack),
    .poll_tick(poll_tick), .poll_last(poll_last), .lock_seen(lock_q),
    .start_req(start_req), .stop_req(stop_req), .pll_on(pll_on),
    .pll_ready(pll_ready), .poll_run(poll_run), .busy(busy),
    .timeout_hit(timeout_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q      <= 1'b0;
      timeout_err <= 1'b0;
      reg_rdata   <= '0;
    end else begin
      lock_q <= pll_ready_in;
      if (timeout_hit)    timeout_err <= 1'b1;
      else if (tmo_clear) timeout_err <= 1'b0;
      reg_rdata <= '0;
      case (reg_addr)
        ADDR_VOTE_SET: reg_rdata <= votes;
        ADDR_STATUS: begin
          reg_rdata[STAT_BUSY]  <= busy;
          reg_rdata[STAT_ON]    <= pll_on;
          reg_rdata[STAT_READY] <= pll_ready;
          reg_rdata[STAT_TMO]   <= timeout_err;
        end
        default: ;
      endcase
    end
  end

  assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (timeout_err && !tmo_clear) |=> timeout_err);

  assert_timeout_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    (tmo_clear && !timeout_hit) |=> !timeout_err);
endmodule

// File: tb/tb_pll_vote_arbiter.sv
module tb_pll_vote_arbiter;
  localparam int N = 4;
  localparam int GAP = 3;
  localparam int LIM = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] boot_votes = '0, hw_set = '0, hw_clr = '0, wdata = '0;
  logic [1:0] addr = 2'd0;
  logic wr = 1'b0;
  logic [N-1:0] rdata;
  logic start_req, stop_req, pll_on, pll_ready, timeout_err;
  logic man_start = 1'b0, man_stop = 1'b0, auto_start = 1'b0, auto_stop = 1'b0;
  logic auto_en = 1'b1, ready_in = 1'b1;
  logic start_ack, stop_ack;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  assign start_ack = man_start | auto_start;
  assign stop_ack  = man_stop | auto_stop;

  always @(posedge clk) begin
    auto_start <= auto_en && start_req && !auto_start;
    auto_stop  <= auto_en && stop_req && !auto_stop;
  end

  pll_vote_arbiter #(.N_MASTERS(N), .HOST_BIT(1), .POLL_GAP(GAP), .POLL_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .boot_votes(boot_votes), .hw_vote_set(hw_set),
    .hw_vote_clr(hw_clr), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .start_req(start_req), .start_ack(start_ack),
    .stop_req(stop_req), .stop_ack(stop_ack), .pll_ready_in(ready_in),
    .pll_on(pll_on), .pll_ready(pll_ready), .timeout_err(timeout_err)
  );

  typedef struct packed { logic [N-1:0] set; logic [N-1:0] clr; logic [N-1:0] exp; } vec_t;
  localparam vec_t VECS [6] = '{
    '{4'b0010, 4'b0000, 4'b0010},
    '{4'b0101, 4'b0000, 4'b0111},
    '{4'b0000, 4'b0011, 4'b0100},
    '{4'b1000, 4'b0100, 4'b1000},
    '{4'b0001, 4'b0001, 4'b1001},
    '{4'b0000, 4'b1111, 4'b0000}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [1:0] a, logic [N-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    cyc(1);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [N-1:0] d);
    addr = a;
    cyc(2);
    d = rdata;
  endtask

  task automatic ack_start();
    man_start = 1'b1; cyc(1); man_start = 1'b0;
  endtask

  task automatic ack_stop();
    man_stop = 1'b1; cyc(1); man_stop = 1'b0;
  endtask

  task automatic do_reset(logic [N-1:0] boot);
    boot_votes = boot; rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] rd;
    do_reset('0);
    // R1 reset state
    check("R1 on", pll_on, 0);
    check("R1 ready", pll_ready, 0);
    check("R1 timeout", timeout_err, 0);
    check("R1 start_req", start_req, 0);
    check("R1 stop_req", stop_req, 0);
    reg_read(2'd0, rd);
    check("R1 votes", rd, 0);

    // R2/R3 vector walk: merged hardware set/clear strobes
    addr = 2'd0;
    for (int i = 0; i < 6; i++) begin
      hw_set = VECS[i].set; hw_clr = VECS[i].clr;
      cyc(1);
      hw_set = '0; hw_clr = '0;
      cyc(1);
      check("R2 R3 vote mask", rdata, VECS[i].exp);
    end
    cyc(10);
    check("R10 idle after walk", pll_on, 0);

    // R4 start handshake held until ack
    auto_en = 1'b0; ready_in = 1'b0;
    reg_write(2'd0, 4'b0010);
    cyc(5);
    check("R4 start_req held", start_req, 1);
    check("R5 on before ack", pll_on, 0);
    ack_start();
    check("R5 on after ack", pll_on, 1);
    check("R4 start_req dropped", start_req, 0);
    ready_in = 1'b1;
    cyc(GAP + 3);
    check("R6 ready", pll_ready, 1);
    reg_read(2'd2, rd);
    check("R8 status read", rd, 4'b0110);

    // R9: last vote removal only
    hw_set = 4'b0100; cyc(1); hw_set = '0;
    reg_write(2'd1, 4'b0010);
    cyc(3);
    check("R9 no stop with vote", stop_req, 0);
    check("R9 still on", pll_on, 1);
    hw_clr = 4'b0100; cyc(1); hw_clr = '0;
    cyc(2);
    check("R9 stop_req", stop_req, 1);
    check("R9 ready dropped", pll_ready, 0);
    check("R11 start low in stop", start_req, 0);
    check("R10 on until ack", pll_on, 1);
    ack_stop();
    check("R10 off after ack", pll_on, 0);
    cyc(2);
    check("R10 stays off", start_req, 0);

    // R10: vote during stop restarts after stop completes
    reg_write(2'd0, 4'b1000);
    cyc(2);
    ack_start();
    cyc(GAP * 2 + 3);
    reg_write(2'd1, 4'b1000);
    cyc(2);
    check("R9 stop for restart", stop_req, 1);
    hw_set = 4'b0001; cyc(1); hw_set = '0;
    cyc(2);
    check("R10 stop continues", stop_req, 1);
    ack_stop();
    check("R10 off at ack", pll_on, 0);
    check("R10 restart", start_req, 1);
    ack_start();
    check("R5 on again", pll_on, 1);

    // R7 timeout, R8 clear
    cyc(GAP * 2 + 3);
    hw_clr = 4'b0001; cyc(1); hw_clr = '0;
    cyc(2);
    ack_stop();
    ready_in = 1'b0;
    reg_write(2'd0, 4'b0010);
    cyc(2);
    ack_start();
    cyc(GAP * LIM - 4);
    check("R7 no early timeout", timeout_err, 0);
    cyc(7);
    check("R7 timeout", timeout_err, 1);
    check("R7 ready low", pll_ready, 0);
    cyc(3);
    check("R7 sticky", timeout_err, 1);
    reg_read(2'd2, rd);
    check("R8 status tmo", rd, 4'b1010);
    reg_write(2'd2, 4'b0111);
    cyc(1);
    check("R8 zero write keeps", timeout_err, 1);
    reg_write(2'd2, 4'b1000);
    cyc(1);
    check("R8 w1c", timeout_err, 0);

    // R1 hand-off with host bit preset
    auto_en = 1'b1; ready_in = 1'b1;
    do_reset(4'b0010);
    check("R1 handoff on", pll_on, 1);
    check("R1 handoff ready", pll_ready, 1);
    check("R1 handoff no start", start_req, 0);
    reg_read(2'd0, rd);
    check("R1 handoff votes", rd, 4'b0010);
    do_reset(4'b0100);
    check("R1 non-host boot off", pll_on, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule